// File: doc/BRIEF.md
# Tagged Zero-Address Stack Executor

This block runs a stream of 8-bit operator syllables against a small hardware stack. No syllable names a register. Each operator takes its operands from the top of the stack and leaves its result there. Every stack word holds a 3-bit tag, a 48-bit primary field and a 48-bit extension field. The extension field carries the low half of a double-precision value. Operators choose their behaviour from the operand tags. A single add opcode does single-precision work on tag-0 operands. It does double-precision work when either operand carries tag 2.

The stack holds `DEPTH` entries. The top entry is called A, the one below it B, and the one below that C. A synchronous word-array memory port serves value loads and guarded stores. The memory returns read data one cycle after the read request. A store first reads the target word. A target with an odd tag refuses the store. Syllables arrive over a valid/ready handshake, one per transfer. Faults are reported as single-cycle pulses on three separate outputs.

Top module: `tstk_exec`

## Requirements
- R1: One syllable is taken per cycle in which `syl_valid` and `syl_ready` are both high. Codes 0x00–0x3F are value loads and codes 0x40–0x7F are address-couple pushes; in both, bits [5:0] form the couple. After accepting a load or a store, `syl_ready` is low for exactly one cycle.
- R2: An address-couple push places a word on top with tag 1, the couple in the primary field and zero in the extension field.
- R3: A value load reads the memory word at the couple. In the cycle after the request, it pushes that word with its tag and both fields.
- R4: Add (0x80) and subtract (0x81) pop one word and replace the new top with B+A or B−A, taken modulo 2^48 on the primary field, when neither tag is 2. The result has tag 0 and a zero extension.
- R5: When either operand of add or subtract has tag 2, the operation runs on the 96-bit value {primary, extension} of each word. The result has tag 2.
- R6: Exchange (0x82) swaps A and B. Duplicate (0x83) pushes a copy of A. Delete (0x84) pops A.
- R7: Rotate up (0x85) gives new A=C, B=A, C=B. Rotate down (0x86) gives new A=B, B=C, C=A.
- R8: Zero (0x87) and one (0x88) push the value 0 or 1. Literal (0x89) takes the next accepted syllable as an 8-bit value and pushes it. Every literal has tag 0 and a zero extension.
- R9: Codes 0x90–0x95 test B against A on the signed primary field: less, greater-or-equal, greater, less-or-equal, equal, not-equal, in that code order. They set `tf_flag` to the outcome and leave the stack unchanged.
- R10: Code 0x96 is true when the primary and extension fields of A and B match. Code 0x97 is true only when the tags match as well.
- R11: Store (0x8A) reads the target at the address in A's low primary bits. If the target's tag is even, it writes B there on the next cycle and pops both words.
- R12: If the store target's tag is odd, `protect_fault` pulses, memory is not written and the stack is unchanged.
- R13: A syllable that would push onto a full stack, or that needs more words than the stack holds, raises a one-cycle `stack_fault` pulse and has no other effect.
- R14: Code 0xFF raises a one-cycle `invalid_fault` pulse and leaves the stack unchanged. Any other unassigned code has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syl_valid | input | 1 | Syllable offered |
| syl_data | input | 8 | Syllable code |
| syl_ready | output | 1 | Syllable can be accepted |
| mem_en | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wtag | output | 3 | Tag written |
| mem_wdata | output | 48 | Primary field written |
| mem_wext | output | 48 | Extension field written |
| mem_rtag | input | 3 | Tag read, valid one cycle after `mem_en` |
| mem_rdata | input | 48 | Primary field read |
| mem_rext | input | 48 | Extension field read |
| stk_depth | output | clog2(DEPTH+1) | Number of words on the stack |
| a_tag | output | 3 | Tag of top word (0 when empty) |
| a_data | output | 48 | Primary field of top word |
| a_ext | output | 48 | Extension field of top word |
| b_tag | output | 3 | Tag of second word |
| b_data | output | 48 | Primary field of second word |
| b_ext | output | 48 | Extension field of second word |
| tf_flag | output | 1 | Result of the latest comparison |
| stack_fault | output | 1 | Over/underflow pulse |
| protect_fault | output | 1 | Refused-store pulse |
| invalid_fault | output | 1 | Invalid-operator pulse |

## Verification
The bench builds a double-precision add whose extension field carries into the primary field. A block that ignored the tags would return a primary field of 0 instead of 1. It also runs a signed comparison of −1 against 1, which an unsigned comparator gets wrong. A store is aimed at a word with tag 1 and read back afterwards. This shows whether a refused store slipped a write through or popped the stack anyway. Over- and underflow are driven on a full stack, an empty one and a two-operand add holding one word. A design that checks depth wrongly would change the depth or the top word.

// File: rtl/tstk_pkg.sv
package tstk_pkg;

  localparam int WORD_W = 48;
  localparam int TAG_W  = 3;

  localparam logic [TAG_W-1:0] TAG_SGL = 3'd0;
  localparam logic [TAG_W-1:0] TAG_REF = 3'd1;
  localparam logic [TAG_W-1:0] TAG_DBL = 3'd2;

  // opcode map for the upper half of the code space
  localparam logic [7:0] SY_ADD  = 8'h80;
  localparam logic [7:0] SY_SUB  = 8'h81;
  localparam logic [7:0] SY_EXCH = 8'h82;
  localparam logic [7:0] SY_DUPL = 8'h83;
  localparam logic [7:0] SY_DLET = 8'h84;
  localparam logic [7:0] SY_RUP  = 8'h85;
  localparam logic [7:0] SY_RDN  = 8'h86;
  localparam logic [7:0] SY_ZERO = 8'h87;
  localparam logic [7:0] SY_ONE  = 8'h88;
  localparam logic [7:0] SY_LIT  = 8'h89;
  localparam logic [7:0] SY_STOD = 8'h8A;
  localparam logic [4:0] SY_CMP_HI = 5'b10010;  // 0x90..0x97
  localparam logic [7:0] SY_BAD  = 8'hFF;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } tword_t;

  typedef enum logic [3:0] {
    OP_NOP, OP_VALC, OP_NAMC, OP_ADD, OP_SUB, OP_EXCH, OP_DUPL, OP_DLET,
    OP_RUP, OP_RDN, OP_ZERO, OP_ONE, OP_LIT, OP_STOD, OP_CMP, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    CMP_LT, CMP_GE, CMP_GT, CMP_LE, CMP_EQ, CMP_NE, CMP_BITS, CMP_SAME
  } cmp_e;

  // add or subtract, precision chosen by the operand tags
  function automatic tword_t tag_arith(input tword_t b, input tword_t a, input logic sub);
    logic [2*WORD_W-1:0] x;
    logic [2*WORD_W-1:0] y;
    logic [2*WORD_W-1:0] r;
    tword_t res;
    x = {b.hi, b.lo};
    y = {a.hi, a.lo};
    r = sub ? (x - y) : (x + y);
    if (b.tag == TAG_DBL || a.tag == TAG_DBL) begin
      res.tag = TAG_DBL;
      res.hi  = r[2*WORD_W-1:WORD_W];
      res.lo  = r[WORD_W-1:0];
    end else begin
      res.tag = TAG_SGL;
      res.hi  = sub ? (b.hi - a.hi) : (b.hi + a.hi);
      res.lo  = '0;
    end
    return res;
  endfunction

  // relation of B to A
  function automatic logic tag_relate(input tword_t b, input tword_t a, input cmp_e k);
    logic signed [WORD_W-1:0] sb;
    logic signed [WORD_W-1:0] sa;
    logic t;
    sb = b.hi;
    sa = a.hi;
    case (k)
      CMP_LT:   t = (sb <  sa);
      CMP_GE:   t = (sb >= sa);
      CMP_GT:   t = (sb >  sa);
      CMP_LE:   t = (sb <= sa);
      CMP_EQ:   t = (sb == sa);
      CMP_NE:   t = (sb != sa);
      CMP_BITS: t = ({b.hi, b.lo} == {a.hi, a.lo});
      default:  t = (b == a);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tstk_decode.sv
module tstk_decode
  import tstk_pkg::*;
(
  input  logic [7:0] syl,
  output op_e        op,
  output cmp_e       kind,
  output logic [1:0] need,
  output logic       grows
);

  always_comb begin
    op    = OP_NOP;
    need  = 2'd0;
    grows = 1'b0;
    kind  = cmp_e'(syl[2:0]);
    if (syl[7:6] == 2'b00) begin
      op    = OP_VALC;
      grows = 1'b1;
    end else if (syl[7:6] == 2'b01) begin
      op    = OP_NAMC;
      grows = 1'b1;
    end else if (syl[7:3] == SY_CMP_HI) begin
      op   = OP_CMP;
      need = 2'd2;
    end else begin
      case (syl)
        SY_ADD:  begin op = OP_ADD;  need = 2'd2; end
        SY_SUB:  begin op = OP_SUB;  need = 2'd2; end
        SY_EXCH: begin op = OP_EXCH; need = 2'd2; end
        SY_DUPL: begin op = OP_DUPL; need = 2'd1; grows = 1'b1; end
        SY_DLET: begin op = OP_DLET; need = 2'd1; end
        SY_RUP:  begin op = OP_RUP;  need = 2'd3; end
        SY_RDN:  begin op = OP_RDN;  need = 2'd3; end
        SY_ZERO: begin op = OP_ZERO; grows = 1'b1; end
        SY_ONE:  begin op = OP_ONE;  grows = 1'b1; end
        SY_LIT:  begin op = OP_LIT;  grows = 1'b1; end
        SY_STOD: begin op = OP_STOD; need = 2'd2; end
        SY_BAD:  op = OP_BAD;
        default: op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/tstk_alu.sv
module tstk_alu
  import tstk_pkg::*;
(
  input  tword_t a,
  input  tword_t b,
  input  logic   sub,
  input  cmp_e   kind,
  output tword_t sum,
  output logic   flag
);

  always_comb begin
    sum  = tag_arith(b, a, sub);
    flag = tag_relate(b, a, kind);
  end

endmodule

// File: rtl/tstk_exec.sv
module tstk_exec
  import tstk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syl_valid,
  input  logic [7:0]        syl_data,
  output logic              syl_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [TAG_W-1:0]  mem_wtag,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] mem_wext,
  input  logic [TAG_W-1:0]  mem_rtag,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] mem_rext,
  output logic [SP_W-1:0]   stk_depth,
  output logic [TAG_W-1:0]  a_tag,
  output logic [WORD_W-1:0] a_data,
  output logic [WORD_W-1:0] a_ext,
  output logic [TAG_W-1:0]  b_tag,
  output logic [WORD_W-1:0] b_data,
  output logic [WORD_W-1:0] b_ext,
  output logic              tf_flag,
  output logic              stack_fault,
  output logic              protect_fault,
  output logic              invalid_fault
);

  localparam int NWP = 3;  // write ports into the stack array

  typedef enum logic [1:0] {ST_IDLE, ST_LIT, ST_VALC, ST_STOD} st_e;

  st_e            state, st_nxt;
  logic [SP_W-1:0] sp, sp_nxt;
  tword_t         stk [DEPTH];
  logic            tf_nxt;

  logic [IDX_W-1:0] ia, ib, ic, ip;
  tword_t          wa, wb, wc;

  logic [NWP-1:0]   we;
  logic [IDX_W-1:0] widx [NWP];
  tword_t           wval [NWP];

  // named events
  logic   fire, idle_fire, stk_err, exec;
  op_e    dec_op;
  cmp_e   dec_kind;
  logic [1:0] dec_need;
  logic   dec_grows;
  tword_t alu_sum;
  logic   alu_flag;
  tword_t lit_w, namc_w, one_w, zero_w, rd_w;
  logic   st_refuse;

  tstk_decode u_dec (
    .syl   (syl_data),
    .op    (dec_op),
    .kind  (dec_kind),
    .need  (dec_need),
    .grows (dec_grows)
  );

  tstk_alu u_alu (
    .a    (wa),
    .b    (wb),
    .sub  (dec_op == OP_SUB),
    .kind (dec_kind),
    .sum  (alu_sum),
    .flag (alu_flag)
  );

  // top-of-stack view
  always_comb begin
    ia = IDX_W'(sp - SP_W'(1));
    ib = IDX_W'(sp - SP_W'(2));
    ic = IDX_W'(sp - SP_W'(3));
    ip = IDX_W'(sp);
    wa = (sp >= SP_W'(1)) ? stk[ia] : '0;
    wb = (sp >= SP_W'(2)) ? stk[ib] : '0;
    wc = (sp >= SP_W'(3)) ? stk[ic] : '0;
  end

  // words built from the syllable or the memory
  always_comb begin
    lit_w  = '{tag: TAG_SGL, hi: WORD_W'(syl_data), lo: '0};
    namc_w = '{tag: TAG_REF, hi: WORD_W'(syl_data[5:0]), lo: '0};
    one_w  = '{tag: TAG_SGL, hi: WORD_W'(1), lo: '0};
    zero_w = '0;
    rd_w   = '{tag: mem_rtag, hi: mem_rdata, lo: mem_rext};
  end

  assign syl_ready = (state == ST_IDLE) || (state == ST_LIT);
  assign fire      = syl_valid && syl_ready;
  assign idle_fire = fire && (state == ST_IDLE);
  assign stk_err   = idle_fire &&
                     ((sp < SP_W'(dec_need)) || (dec_grows && sp == SP_W'(DEPTH)));
  assign exec      = idle_fire && !stk_err;
  assign st_refuse = (state == ST_STOD) && mem_rtag[0];

  // memory port
  always_comb begin
    mem_en   = exec && (dec_op == OP_VALC || dec_op == OP_STOD);
    mem_we   = (state == ST_STOD) && !mem_rtag[0];
    mem_addr = (idle_fire && dec_op == OP_VALC) ? ADDR_W'(syl_data[5:0])
                                                : wa.hi[ADDR_W-1:0];
    mem_wtag  = wb.tag;
    mem_wdata = wb.hi;
    mem_wext  = wb.lo;
  end

  // next-state and stack write ports
  always_comb begin
    we     = '0;
    for (int k = 0; k < NWP; k++) begin
      widx[k] = '0;
      wval[k] = '0;
    end
    sp_nxt = sp;
    st_nxt = state;
    tf_nxt = tf_flag;
    case (state)
      ST_LIT: begin
        if (fire) begin
          we[0] = 1'b1; widx[0] = ip; wval[0] = lit_w;
          sp_nxt = sp + SP_W'(1);
          st_nxt = ST_IDLE;
        end
      end
      ST_VALC: begin
        we[0] = 1'b1; widx[0] = ip; wval[0] = rd_w;
        sp_nxt = sp + SP_W'(1);
        st_nxt = ST_IDLE;
      end
      ST_STOD: begin
        if (!mem_rtag[0]) sp_nxt = sp - SP_W'(2);
        st_nxt = ST_IDLE;
      end
      default: begin
        if (exec) begin
          case (dec_op)
            OP_VALC: st_nxt = ST_VALC;
            OP_STOD: st_nxt = ST_STOD;
            OP_LIT:  st_nxt = ST_LIT;
            OP_NAMC: begin
              we[0] = 1'b1; widx[0] = ip; wval[0] = namc_w; sp_nxt = sp + SP_W'(1);
            end
            OP_ZERO: begin
              we[0] = 1'b1; widx[0] = ip; wval[0] = zero_w; sp_nxt = sp + SP_W'(1);
            end
            OP_ONE: begin
              we[0] = 1'b1; widx[0] = ip; wval[0] = one_w; sp_nxt = sp + SP_W'(1);
            end
            OP_DUPL: begin
              we[0] = 1'b1; widx[0] = ip; wval[0] = wa; sp_nxt = sp + SP_W'(1);
            end
            OP_DLET: sp_nxt = sp - SP_W'(1);
            OP_ADD, OP_SUB: begin
              we[0] = 1'b1; widx[0] = ib; wval[0] = alu_sum; sp_nxt = sp - SP_W'(1);
            end
            OP_EXCH: begin
              we[1:0] = 2'b11;
              widx[0] = ia; wval[0] = wb;
              widx[1] = ib; wval[1] = wa;
            end
            OP_RUP: begin
              we = 3'b111;
              widx[0] = ia; wval[0] = wc;
              widx[1] = ib; wval[1] = wa;
              widx[2] = ic; wval[2] = wb;
            end
            OP_RDN: begin
              we = 3'b111;
              widx[0] = ia; wval[0] = wb;
              widx[1] = ib; wval[1] = wc;
              widx[2] = ic; wval[2] = wa;
            end
            OP_CMP: tf_nxt = alu_flag;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NWP; k++) begin
      if (we[k]) stk[widx[k]] <= wval[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      sp            <= '0;
      tf_flag       <= 1'b0;
      stack_fault   <= 1'b0;
      protect_fault <= 1'b0;
      invalid_fault <= 1'b0;
    end else begin
      state         <= st_nxt;
      sp            <= sp_nxt;
      tf_flag       <= tf_nxt;
      stack_fault   <= stk_err;
      protect_fault <= st_refuse;
      invalid_fault <= exec && (dec_op == OP_BAD);
    end
  end

  assign stk_depth = sp;
  assign a_tag  = wa.tag;
  assign a_data = wa.hi;
  assign a_ext  = wa.lo;
  assign b_tag  = wb.tag;
  assign b_data = wb.hi;
  assign b_ext  = wb.lo;

  // ---------------- assertions ----------------
  a_r13_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));

  a_r13_fault_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> sp == $past(sp));

  a_r14_bad_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_fault |-> sp == $past(sp));

  a_r12_no_write_odd_tag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_rtag[0]);

  a_r12_refused_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    protect_fault |-> sp == $past(sp));

  a_r1_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !syl_ready);

  a_r13_faults_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stack_fault, protect_fault, invalid_fault}));

endmodule

// File: tb/tstk_exec_tb.sv
module tstk_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syl_valid = 1'b0;
  logic [7:0]  syl_data = 8'h00;
  logic        syl_ready;
  logic        mem_en, mem_we;
  logic [5:0]  mem_addr;
  logic [2:0]  mem_wtag, mem_rtag;
  logic [47:0] mem_wdata, mem_wext, mem_rdata, mem_rext;
  logic [3:0]  stk_depth;
  logic [2:0]  a_tag, b_tag;
  logic [47:0] a_data, a_ext, b_data, b_ext;
  logic        tf_flag, stack_fault, protect_fault, invalid_fault;

  int n_chk = 0;
  int n_err = 0;
  int n_sf = 0;
  int n_pf = 0;
  int n_if = 0;

  always #5 clk = ~clk;

  tstk_exec dut_i (
    .clk(clk), .rst_n(rst_n), .syl_valid(syl_valid), .syl_data(syl_data),
    .syl_ready(syl_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wtag(mem_wtag), .mem_wdata(mem_wdata), .mem_wext(mem_wext),
    .mem_rtag(mem_rtag), .mem_rdata(mem_rdata), .mem_rext(mem_rext),
    .stk_depth(stk_depth), .a_tag(a_tag), .a_data(a_data), .a_ext(a_ext),
    .b_tag(b_tag), .b_data(b_data), .b_ext(b_ext), .tf_flag(tf_flag),
    .stack_fault(stack_fault), .protect_fault(protect_fault),
    .invalid_fault(invalid_fault)
  );

  // word memory model: {tag, primary, extension}
  logic [98:0] mem [64];
  logic [98:0] rd_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      mem[3] <= {3'd2, 48'd0, 48'hFFFF_FFFF_FFFF};
      mem[4] <= {3'd2, 48'd0, 48'd1};
      mem[9] <= {3'd1, 48'h77, 48'd0};
      rd_q   <= '0;
    end else begin
      if (mem_we) mem[mem_addr] <= {mem_wtag, mem_wdata, mem_wext};
      if (mem_en) rd_q <= mem[mem_addr];
    end
  end
  assign mem_rtag  = rd_q[98:96];
  assign mem_rdata = rd_q[95:48];
  assign mem_rext  = rd_q[47:0];

  always @(posedge clk) begin
    if (rst_n) begin
      if (stack_fault)   n_sf++;
      if (protect_fault) n_pf++;
      if (invalid_fault) n_if++;
    end
  end

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] s);
    @(negedge clk);
    while (!syl_ready) @(negedge clk);
    syl_valid = 1'b1;
    syl_data  = s;
    @(posedge clk);
    #1 syl_valid = 1'b0;
    @(negedge clk);
    while (!syl_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // {syllable, expected depth, expected low 16 bits of the top word}
  localparam logic [27:0] VEC [13] = '{
    {8'h88, 4'd1, 16'h0001},
    {8'h88, 4'd2, 16'h0001},
    {8'h80, 4'd1, 16'h0002},
    {8'h89, 4'd1, 16'h0002},
    {8'h05, 4'd2, 16'h0005},
    {8'h81, 4'd1, 16'hFFFD},
    {8'h83, 4'd2, 16'hFFFD},
    {8'h80, 4'd1, 16'hFFFA},
    {8'h87, 4'd2, 16'h0000},
    {8'h82, 4'd2, 16'hFFFA},
    {8'h84, 4'd1, 16'h0000},
    {8'h4A, 4'd2, 16'h000A},
    {8'h84, 4'd1, 16'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset depth", 96'(stk_depth), 96'd0);
    check("R1 reset ready", 96'(syl_ready), 96'd1);
    check("R9 reset flag", 96'(tf_flag), 96'd0);

    // vector walk: R4 R6 R8 R2
    for (int i = 0; i < 13; i++) begin
      send(VEC[i][27:20]);
      check($sformatf("R4/R6/R8 vector %0d depth", i), 96'(stk_depth), 96'(VEC[i][19:16]));
      check($sformatf("R4/R6/R8 vector %0d top", i), 96'(a_data[15:0]), 96'(VEC[i][15:0]));
    end
    send(8'h84);
    check("R6 delete to empty", 96'(stk_depth), 96'd0);

    // R13 underflow and overflow
    send(8'h84);
    check("R13 pop empty fault", 96'(n_sf), 96'd1);
    check("R13 pop empty depth", 96'(stk_depth), 96'd0);
    send(8'h88);
    send(8'h80);
    check("R13 add one word fault", 96'(n_sf), 96'd2);
    check("R13 add one word top", {48'(stk_depth), a_data}, {48'd1, 48'd1});
    send(8'h84);
    for (int i = 0; i < 8; i++) send(8'h88);
    check("R13 full depth", 96'(stk_depth), 96'd8);
    send(8'h87);
    check("R13 push full fault", 96'(n_sf), 96'd3);
    check("R13 push full unchanged", {48'(stk_depth), a_data}, {48'd8, 48'd1});
    for (int i = 0; i < 8; i++) send(8'h84);

    // R14 invalid and unassigned
    send(8'hFF);
    check("R14 invalid fault", 96'(n_if), 96'd1);
    check("R14 invalid depth", 96'(stk_depth), 96'd0);
    send(8'h9F);
    check("R14 unassigned no fault", 96'({n_sf[7:0], n_if[7:0]}), 96'({8'd3, 8'd1}));
    check("R14 unassigned depth", 96'(stk_depth), 96'd0);

    // R2 address-couple push
    send(8'h6A);
    check("R2 couple push", {45'd0, a_tag, a_data}, {45'd0, 3'd1, 48'h2A});
    check("R2 couple ext", 96'(a_ext), 96'd0);
    send(8'h84);

    // R10 bit-pattern vs full compare
    send(8'h41);
    send(8'h88);
    send(8'h96);
    check("R10 pattern equal", 96'(tf_flag), 96'd1);
    send(8'h97);
    check("R10 tags differ", 96'(tf_flag), 96'd0);
    check("R9 compare keeps stack", 96'(stk_depth), 96'd2);
    send(8'h84);
    send(8'h84);

    // R8 literals, R7 rotations
    send(8'h89); send(8'h01);
    send(8'h89); send(8'h02);
    send(8'h89); send(8'h03);
    check("R8 literal top", {45'd0, a_tag, a_data}, {45'd0, 3'd0, 48'd3});
    send(8'h85);
    check("R7 rotate up", {a_data, b_data}, {48'd1, 48'd3});
    send(8'h86);
    check("R7 rotate down", {a_data, b_data}, {48'd3, 48'd2});

    // R9 relations with B=2, A=3
    send(8'h90); check("R9 less", 96'(tf_flag), 96'd1);
    send(8'h92); check("R9 greater", 96'(tf_flag), 96'd0);
    send(8'h94); check("R9 equal", 96'(tf_flag), 96'd0);
    send(8'h91); check("R9 greater-equal", 96'(tf_flag), 96'd0);
    send(8'h93); check("R9 less-equal", 96'(tf_flag), 96'd1);
    send(8'h95); check("R9 not-equal", 96'(tf_flag), 96'd1);

    // R6 exchange and duplicate
    send(8'h82);
    check("R6 exchange", {a_data, b_data}, {48'd2, 48'd3});
    send(8'h83);
    check("R6 duplicate", {a_data, b_data}, {48'd2, 48'd2});
    check("R6 duplicate depth", 96'(stk_depth), 96'd4);
    for (int i = 0; i < 4; i++) send(8'h84);

    // R4 wraparound and R9 signed
    send(8'h87); send(8'h88); send(8'h81);
    check("R4 subtract wraps", {45'd0, a_tag, a_data}, {45'd0, 3'd0, 48'hFFFF_FFFF_FFFF});
    send(8'h88);
    send(8'h90);
    check("R9 signed less", 96'(tf_flag), 96'd1);
    send(8'h84); send(8'h84);

    // R1 and R3: load with busy cycle
    @(negedge clk);
    syl_valid = 1'b1; syl_data = 8'h03;
    @(posedge clk);
    #1 syl_valid = 1'b0;
    @(negedge clk);
    check("R1 busy after load", 96'(syl_ready), 96'd0);
    @(negedge clk);
    check("R1 ready again", 96'(syl_ready), 96'd1);
    check("R3 load word", {a_tag, 45'd0, a_ext}, {3'd2, 45'd0, 48'hFFFF_FFFF_FFFF});
    check("R3 load depth", 96'(stk_depth), 96'd1);

    // R5 double precision with carry
    send(8'h04);
    send(8'h80);
    check("R5 double carry", {a_data, a_ext}, {48'd1, 48'd0});
    check("R5 double tag", 96'(a_tag), 96'd2);
    send(8'h84);
    send(8'h88); send(8'h04); send(8'h80);
    check("R5 mixed tags", {a_data, a_ext}, {48'd1, 48'd1});
    check("R5 mixed tag", 96'(a_tag), 96'd2);
    send(8'h84);

    // R11 store accepted
    send(8'h89); send(8'h2A);
    send(8'h89); send(8'h07);
    send(8'h8A);
    check("R11 store pops", 96'(stk_depth), 96'd0);
    send(8'h07);
    check("R11 stored word", {45'd0, a_tag, a_data}, {45'd0, 3'd0, 48'h2A});
    send(8'h84);

    // R12 store refused
    send(8'h89); send(8'h05);
    send(8'h89); send(8'h09);
    send(8'h8A);
    check("R12 protect fault", 96'(n_pf), 96'd1);
    check("R12 stack kept", {48'(stk_depth), a_data}, {48'd2, 48'd9});
    send(8'h84); send(8'h84);
    send(8'h09);
    check("R12 target unchanged", {45'd0, a_tag, a_data}, {45'd0, 3'd1, 48'h77});

    finish_run();
  end

endmodule